// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with External Input Modes

This block is a general-purpose timer made of a programmable prescaler feeding an 8-bit down-counter. Each time the prescaler completes a full division period, the counter steps down by one. When the counter finishes its last count on the same cycle the prescaler wraps, the block emits a single-cycle interrupt request. It then either stops with the count at zero, or reloads its initial value and keeps going. The live count is available on an output port at all times, and reading it has no side effects.

Counting steps come from one of two sources. The first is the system clock divided by four, taken from a free-running phase counter. The second is an external pin, which is passed through a two-flop synchronizer and edge-detected before use. The pin can also serve in three other roles: as a one-shot trigger that cannot be re-fired while a count is running, as a trigger that reloads and restarts the count on every rising edge, or as a level gate that lets internal ticks through only while the pin is high. Three one-cycle commands control the count: halt, start from the initial value, and resume from the current value.

Top module: `ptmr_top`

## Requirements
- R1: After reset, cnt_value is 0 and running and irq are low.
- R2: The prescaler field cfg_pre set to P divides counting ticks by P. The value 0 means divide by 64.
- R3: irq is high for exactly one cycle, and only when the prescaler wraps while cnt_value is 1. A counter load value of 0 means 256 counter steps.
- R4: When cfg_reload is 0, the block stops at end of count: running drops, cnt_value reads 0, and irq pulses on the same cycle.
- R5: When cfg_reload is 1, the block loads cfg_init again at end of count and keeps running.
- R6: Commands are sampled on a clock edge, with priority halt > start > resume. Halt stops the count and disarms the trigger. Start loads cfg_init and the prescaler, then runs; in the trigger modes it only arms the trigger. Resume runs on from the current values without reloading them.
- R7: While the block is stopped, cnt_value holds its value.
- R8: cfg_mode 0 (and the unused codes 5 to 7) counts ticks of an internal divide-by-four phase counter. That counter starts at 0 on reset, and a tick falls on every cycle in which the phase is 3.
- R9: cfg_mode 1 counts rising edges of ext_in after a two-flop synchronizer. An edge is counted on the third clock edge after ext_in rises.
- R10: cfg_mode 2 uses internal ticks. Once armed, a synchronized rising edge of ext_in loads cfg_init and starts the count. Edges that arrive while running is high are ignored.
- R11: cfg_mode 3 uses internal ticks. While armed, every synchronized rising edge of ext_in loads cfg_init and the prescaler again and restarts the count.
- R12: cfg_mode 4 passes internal ticks to the prescaler only while the synchronized ext_in is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Tick source and external-pin role (0 internal, 1 ext clock, 2 one-shot trigger, 3 retrigger, 4 gate) |
| cfg_reload | input | 1 | 1 = continuous reload, 0 = single pass |
| cfg_pre | input | 6 | Prescaler divide value, 0 means 64 |
| cfg_init | input | 8 | Counter initial value, 0 means 256 |
| cmd_halt | input | 1 | Stop counting and disarm |
| cmd_start | input | 1 | Load initial values and run or arm |
| cmd_resume | input | 1 | Run from current values |
| ext_in | input | 1 | Asynchronous external timer pin |
| cnt_value | output | 8 | Live counter value |
| running | output | 1 | Counter is actively counting |
| irq | output | 1 | One-cycle end-of-count request |

## Verification
The bench builds the block with its default parameters: a 6-bit prescaler, an 8-bit counter and an internal divider of four. Under these settings the extreme encodings can be reached within the run. Divide-by-64 is checked with 128 external edges, and the 256-count load is checked with 256 edges, where the count must read 1 just before the final edge. A cycle-level reference model drives randomized modes, commands and pin activity, so the command priorities, trigger ignoring and gate behaviour are all compared against the same schedule.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [2:0] {
        SRC_INT       = 3'd0,
        SRC_EXTCLK    = 3'd1,
        SRC_TRIG_ONCE = 3'd2,
        SRC_TRIG_RE   = 3'd3,
        SRC_GATE      = 3'd4
    } src_mode_e;

    // Decoded command set for one clock edge, after priority is applied
    typedef struct packed {
        logic halt;
        logic start;
        logic resume;
        logic trig;
    } ctl_t;

    function automatic logic is_trig_mode(input logic [2:0] m);
        return (m == SRC_TRIG_ONCE) || (m == SRC_TRIG_RE);
    endfunction

    function automatic ctl_t resolve_ctl(input logic halt, input logic start,
                                         input logic resume, input logic trig);
        ctl_t c;
        c.halt   = halt;
        c.start  = !halt && start;
        c.resume = !halt && !start && resume;
        c.trig   = !halt && !start && !resume && trig;
        return c;
    endfunction

endpackage

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] && !prev;
endmodule

// File: rtl/ptmr_tick_src.sv
module ptmr_tick_src
    import ptmr_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  logic       pin_level,
    input  logic       pin_rise,
    output logic       tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] phase;
    logic          int_tick;

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + DW'(1);
    end

    assign int_tick = (phase == LAST);

    always_comb begin
        case (src_mode_e'(mode))
            SRC_EXTCLK: tick = pin_rise;
            SRC_GATE:   tick = int_tick && pin_level;
            default:    tick = int_tick;
        endcase
    end
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         advance,
    input  logic [W-1:0] div_cfg,
    output logic         wrap
);
    // Holds (remaining - 1); a config of 0 therefore reloads all ones = 2**W
    logic [W-1:0] rem;
    logic [W-1:0] start_val;

    assign start_val = div_cfg - W'(1);
    assign wrap      = advance && (rem == '0);

    always_ff @(posedge clk) begin
        if (rst)               rem <= '0;
        else if (load)         rem <= start_val;
        else if (advance) begin
            if (rem == '0)     rem <= start_val;
            else               rem <= rem - W'(1);
        end
    end
endmodule

// File: rtl/ptmr_downcount.sv
module ptmr_downcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         reload_en,
    input  logic [W-1:0] init_val,
    output logic [W-1:0] value,
    output logic         eoc
);
    localparam logic [W-1:0] ONE = W'(1);

    assign eoc = step && (value == ONE);

    always_ff @(posedge clk) begin
        if (rst)                value <= '0;
        else if (load)          value <= init_val;
        else if (step) begin
            if (value == ONE)   value <= reload_en ? init_val : '0;
            else                value <= value - ONE;
        end
    end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int PRE_W     = 6,
    parameter int CNT_W     = 8,
    parameter int INT_DIV   = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_reload,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_init,
    input  logic             cmd_halt,
    input  logic             cmd_start,
    input  logic             cmd_resume,
    input  logic             ext_in,
    output logic [CNT_W-1:0] cnt_value,
    output logic             running,
    output logic             irq
);
    logic pin_level, pin_rise, tick;
    logic armed, run_q, irq_q;
    logic trig_req, load, advance, pre_wrap, eoc;
    ctl_t ctl;

    ptmr_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_in),
        .level(pin_level), .rise(pin_rise)
    );

    ptmr_tick_src #(.DIV(INT_DIV)) u_tick (
        .clk(clk), .rst(rst), .mode(cfg_mode),
        .pin_level(pin_level), .pin_rise(pin_rise), .tick(tick)
    );

    // Trigger firing: one-shot needs an idle counter, retrigger fires whenever armed
    always_comb begin
        trig_req = 1'b0;
        if (armed && pin_rise) begin
            if (src_mode_e'(cfg_mode) == SRC_TRIG_RE)        trig_req = 1'b1;
            else if (src_mode_e'(cfg_mode) == SRC_TRIG_ONCE) trig_req = !run_q;
        end
    end

    assign ctl     = resolve_ctl(cmd_halt, cmd_start, cmd_resume, trig_req);
    assign load    = ctl.start || ctl.trig;
    assign advance = run_q && tick && !ctl.halt && !ctl.start && !ctl.resume && !ctl.trig;

    ptmr_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .div_cfg(cfg_pre), .wrap(pre_wrap)
    );

    ptmr_downcount #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .step(pre_wrap),
        .reload_en(cfg_reload), .init_val(cfg_init),
        .value(cnt_value), .eoc(eoc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= eoc;
            if (ctl.halt) begin
                armed <= 1'b0;
                run_q <= 1'b0;
            end else if (ctl.start) begin
                armed <= 1'b1;
                run_q <= !is_trig_mode(cfg_mode);
            end else if (ctl.resume) begin
                armed <= 1'b1;
                run_q <= 1'b1;
            end else if (ctl.trig) begin
                run_q <= 1'b1;
            end else if (eoc && !cfg_reload) begin
                run_q <= 1'b0;
            end
        end
    end

    assign running = run_q;
    assign irq     = irq_q;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cfg_mode,
    input logic             cfg_reload,
    input logic [CNT_W-1:0] cfg_init,
    input logic             cmd_halt,
    input logic             cmd_start,
    input logic             cmd_resume,
    input logic [CNT_W-1:0] cnt_value,
    input logic             running,
    input logic             irq
);
    // R3: a request only follows a cycle of active counting
    a_r3_irq_needs_run: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(running));

    // R4: single pass ends stopped at zero
    a_r4_single_stop: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(cfg_reload)) |-> (!running && cnt_value == '0));

    // R5: continuous mode stays running with the reloaded value
    a_r5_reload_runs: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(cfg_reload)) |-> (running && cnt_value == $past(cfg_init)));

    // R6: halt leaves the timer stopped
    a_r6_halt_stops: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_halt) |-> !running);

    // R7: stopped without start, resume or trigger role means the count holds
    a_r7_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!$past(running) && !$past(cmd_start) && !$past(cmd_resume)
         && !is_trig_mode($past(cfg_mode))) |-> $stable(cnt_value));

    // R2: without a start, the count only holds, steps by one, reloads or ends at zero
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_start) |-> (cnt_value == $past(cnt_value)
                            || cnt_value == $past(cnt_value) - CNT_W'(1)
                            || cnt_value == $past(cfg_init)
                            || cnt_value == '0));
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_reload(cfg_reload),
    .cfg_init(cfg_init), .cmd_halt(cmd_halt), .cmd_start(cmd_start),
    .cmd_resume(cmd_resume), .cnt_value(cnt_value), .running(running), .irq(irq)
);

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_mode = 3'd0;
    logic       cfg_reload = 1'b0;
    logic [5:0] cfg_pre = 6'd1;
    logic [7:0] cfg_init = 8'd1;
    logic       cmd_halt = 1'b0, cmd_start = 1'b0, cmd_resume = 1'b0;
    logic       ext_in = 1'b0;
    logic [7:0] cnt_value;
    logic       running, irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    ptmr_top dut_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_reload(cfg_reload),
        .cfg_pre(cfg_pre), .cfg_init(cfg_init), .cmd_halt(cmd_halt),
        .cmd_start(cmd_start), .cmd_resume(cmd_resume), .ext_in(ext_in),
        .cnt_value(cnt_value), .running(running), .irq(irq)
    );

    // Reference model built from the requirements, stepped once per clock edge
    logic       m_s1, m_s2, m_s3;
    logic [1:0] m_phase;
    logic [5:0] m_rem;
    logic [7:0] m_cnt;
    logic       m_run, m_arm, m_irq;

    function automatic bit mdl_tick(input logic [2:0] m, input logic [1:0] ph,
                                    input logic lvl, input logic rs);
        if (m == 3'd1) return rs;
        if (m == 3'd4) return (ph == 2'd3) && lvl;
        return ph == 2'd3;
    endfunction

    always @(posedge clk) begin : model
        logic rs, tk, trg, ld, adv, wr, eo;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_phase = 0; m_rem = 0;
            m_cnt = 0; m_run = 0; m_arm = 0; m_irq = 0;
        end else begin
            rs  = m_s2 && !m_s3;
            tk  = mdl_tick(cfg_mode, m_phase, m_s2, rs);
            trg = m_arm && rs && ((cfg_mode == 3'd3) || (cfg_mode == 3'd2 && !m_run));
            if (cmd_halt || cmd_start || cmd_resume) trg = 0;
            ld  = !cmd_halt && (cmd_start || trg);
            adv = m_run && tk && !cmd_halt && !cmd_start && !cmd_resume && !trg;
            wr  = adv && m_rem == 0;
            eo  = wr && m_cnt == 8'd1;
            if (ld) begin
                m_rem = cfg_pre - 6'd1;
                m_cnt = cfg_init;
            end else if (adv) begin
                m_rem = (m_rem == 0) ? cfg_pre - 6'd1 : m_rem - 6'd1;
                if (wr) m_cnt = (m_cnt == 8'd1) ? (cfg_reload ? cfg_init : 8'd0) : m_cnt - 8'd1;
            end
            m_irq = eo;
            if (cmd_halt) begin m_run = 0; m_arm = 0; end
            else if (cmd_start) begin m_arm = 1; m_run = !(cfg_mode == 3'd2 || cfg_mode == 3'd3); end
            else if (cmd_resume) begin m_arm = 1; m_run = 1; end
            else if (trg) m_run = 1;
            else if (eo && !cfg_reload) m_run = 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
            m_phase = m_phase + 2'd1;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock cycle: wait past the edge, compare outputs against the model
    task automatic cyc();
        @(negedge clk);
        check(cur_req, cnt_value, m_cnt, "cnt_value");
        check(cur_req, running, m_run, "running");
        check(cur_req, irq, m_irq, "irq");
        if (irq) irq_seen++;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_cmd(input int which);
        if (which == 0) cmd_halt = 1;
        if (which == 1) cmd_start = 1;
        if (which == 2) cmd_resume = 1;
        cyc();
        cmd_halt = 0; cmd_start = 0; cmd_resume = 0;
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1; cycles(2);
            ext_in = 0; cycles(2);
        end
    endtask

    task automatic setup(input logic [2:0] m, input logic rl, input logic [5:0] p, input logic [7:0] iv);
        pulse_cmd(0);
        ext_in = 0; cycles(4);
        cfg_mode = m; cfg_reload = rl; cfg_pre = p; cfg_init = iv;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int start_irq;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        @(negedge clk);
        check("R1", cnt_value, 0, "cnt after reset");
        check("R1", running, 0, "running after reset");
        check("R1", irq, 0, "irq after reset");

        // R8 and R4: internal clock, divide by 1, three counts, single pass
        cur_req = "R8";
        setup(3'd0, 1'b0, 6'd1, 8'd3);
        start_irq = irq_seen;
        pulse_cmd(1);
        cycles(40);
        check("R4", irq_seen - start_irq, 1, "single-pass irq count");
        check("R4", running, 0, "stopped after single pass");
        check("R4", cnt_value, 0, "count zero after single pass");

        // R2 and R9: external clock, prescaler code 0 (64), init 2, continuous
        cur_req = "R9";
        setup(3'd1, 1'b1, 6'd0, 8'd2);
        pulse_cmd(1);
        start_irq = irq_seen;
        ext_edges(127); cycles(6);
        check("R2", irq_seen - start_irq, 0, "no irq before 128 edges");
        ext_edges(1); cycles(6);
        check("R2", irq_seen - start_irq, 1, "irq after 128 edges");
        check("R5", cnt_value, 2, "reloaded after end of count");
        check("R5", running, 1, "still running in reload mode");

        // R3: load value 0 means 256 counts
        cur_req = "R3";
        setup(3'd1, 1'b1, 6'd1, 8'd0);
        pulse_cmd(1);
        start_irq = irq_seen;
        ext_edges(255); cycles(6);
        check("R3", cnt_value, 1, "count after 255 edges");
        check("R3", irq_seen - start_irq, 0, "no irq before 256 edges");
        ext_edges(1); cycles(6);
        check("R3", irq_seen - start_irq, 1, "irq after 256 edges");

        // R6 and R7: halt holds, resume continues, start reloads
        cur_req = "R7";
        setup(3'd1, 1'b0, 6'd1, 8'd20);
        pulse_cmd(1);
        ext_edges(5); cycles(6);
        check("R6", cnt_value, 15, "count after 5 edges");
        pulse_cmd(0);
        ext_edges(4); cycles(6);
        check("R7", cnt_value, 15, "count held while halted");
        pulse_cmd(2);
        ext_edges(3); cycles(6);
        check("R6", cnt_value, 12, "resume continues from held value");
        cmd_start = 1; cmd_halt = 1; cyc(); cmd_start = 0; cmd_halt = 0;
        check("R6", running, 0, "halt wins over start");
        pulse_cmd(1);
        check("R6", cnt_value, 20, "start reloads initial value");

        // R10: one-shot trigger, edges during a count are ignored
        cur_req = "R10";
        setup(3'd2, 1'b0, 6'd1, 8'd10);
        pulse_cmd(1);
        cycles(8);
        check("R10", running, 0, "armed but idle before trigger");
        ext_edges(1); cycles(2);
        check("R10", running, 1, "trigger starts count");
        ext_edges(3);
        cycles(60);
        check("R10", running, 0, "count finished despite extra edges");

        // R11: retrigger restarts the count
        cur_req = "R11";
        setup(3'd3, 1'b0, 6'd2, 8'd6);
        pulse_cmd(1);
        start_irq = irq_seen;
        for (int k = 0; k < 6; k++) begin
            ext_in = 1; cycles(4); ext_in = 0; cycles(8);
        end
        check("R11", irq_seen - start_irq, 0, "retriggers hold off end of count");
        cycles(80);
        check("R11", irq_seen - start_irq, 1, "irq after last retrigger");

        // R12: gate low blocks, gate high passes ticks
        cur_req = "R12";
        setup(3'd4, 1'b0, 6'd1, 8'd5);
        pulse_cmd(1);
        cycles(30);
        check("R12", cnt_value, 5, "gate low holds count");
        ext_in = 1; cycles(30);
        ext_in = 0; cycles(10);

        // Randomized mix against the model
        cur_req = "R6";
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) cmd_halt = 1;
            else if (r < 5) cmd_start = 1;
            else if (r < 7) cmd_resume = 1;
            if ($urandom_range(0, 99) < 1) begin
                cfg_mode = 3'($urandom_range(0, 7));
                cfg_reload = 1'($urandom_range(0, 1));
                cfg_pre = 6'($urandom_range(0, 3));
                cfg_init = 8'($urandom_range(0, 6));
            end
            if ($urandom_range(0, 99) < 20) ext_in = ~ext_in;
            cyc();
            cmd_halt = 0; cmd_start = 0; cmd_resume = 0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule